// File: doc/BRIEF.md
# Victim Line Buffer

A small fully associative side store placed beside a direct-mapped cache. It holds only lines that the main cache has pushed out on replacement, and it is consulted only after the main cache misses, so the main cache's hit path keeps its single-lookup timing. The buffer removes most conflict misses, which happen when two hot lines map to the same direct-mapped index.

On a request the main cache presents the missed line address. It also presents the line it is about to displace at that index, if any, with its data and dirty flag. Every stored tag is compared with the request in parallel. On a buffer hit, the stored line is returned to the main cache, and the displaced line takes over the freed slot. This is a swap, so memory is not involved. When there is no displaced line, the slot is simply freed. On a miss, the displaced line is stored in an empty slot if one exists. Otherwise it overwrites the line that entered the buffer longest ago. If that dropped line was dirty, a one-cycle write-back strobe carries its address and data. All results appear one clock after the request.

Top module: `victim_buffer`

## Requirements
- R1: While reset is high, and after its release, every slot is empty: `rsp_valid` and `wb_valid` are 0 during reset, and the first lookup after reset misses.
- R2: A request accepted in cycle t gives `rsp_valid`=1 in cycle t+1, with the result of that request.
- R3: On a hit, `rsp_hit`=1 and `rsp_addr`, `rsp_data` and `rsp_dirty` carry the stored line's address, data and dirty flag.
- R4: A hit with `evict_valid`=1 puts the displaced line into the hit slot. A later lookup of the old address misses, and a later lookup of the displaced address hits with the displaced data and dirty flag.
- R5: A hit with `evict_valid`=0 empties the hit slot, so a repeat lookup of that address misses.
- R6: A miss with `evict_valid`=1 while a slot is empty stores the displaced line there, drops nothing and raises no write-back.
- R7: A miss with `evict_valid`=1 while all slots are full replaces the line inserted longest ago. That line then misses, while the others still hit.
- R8: A replaced line whose dirty flag is 1 raises `wb_valid` for one cycle with its address on `wb_addr` and its data on `wb_data`. A replaced clean line raises no write-back.
- R9: A miss with `evict_valid`=0 changes no stored line and raises no write-back.
- R10: A line placed into a slot by a swap counts as the newest insertion when the next replacement victim is chosen.
- R11: In a cycle with no request, the next cycle has `rsp_valid`=0 and `wb_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request after a main-cache miss |
| req_addr | input | ADDR_W | Line address being looked up |
| evict_valid | input | 1 | The main cache is displacing a valid line with this request |
| evict_addr | input | ADDR_W | Line address of the displaced line |
| evict_data | input | DATA_W | Data of the displaced line |
| evict_dirty | input | 1 | Dirty flag of the displaced line |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_hit | output | 1 | The request hit in the buffer |
| rsp_addr | output | ADDR_W | Address of the returned line |
| rsp_data | output | DATA_W | Data of the returned line (meaningful on hit) |
| rsp_dirty | output | 1 | Dirty flag of the returned line (meaningful on hit) |
| wb_valid | output | 1 | A dirty line was dropped and must be written back |
| wb_addr | output | ADDR_W | Address of the dropped line |
| wb_data | output | DATA_W | Data of the dropped line |

## Verification
The buffer is first filled through empty slots and then driven past capacity. This separates filling a free slot from dropping a line, and a dirty drop from a clean one. A swap hit followed by more fills shows whether the swapped-in line is aged as a fresh insertion; a buffer that kept the slot's old age would evict a different line, and the write-back address exposes it. A hit without a displaced line opens a hole mid-order, and the fills that follow show whether the free slot is taken before any drop and whether the remaining lines keep their relative age. Lookups with no displaced line serve as probes that leave state untouched on a miss.

// File: rtl/vb_pkg.sv
package vb_pkg;

  typedef enum logic [2:0] {
    VB_IDLE      = 3'd0,
    VB_MISS_NOP  = 3'd1,
    VB_HIT_SWAP  = 3'd2,
    VB_HIT_FREE  = 3'd3,
    VB_FILL_FREE = 3'd4,
    VB_FILL_DROP = 3'd5
  } vb_op_e;

endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 26,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0][ADDR_W-1:0]  tags,
  input  logic [N-1:0]              valid,
  input  logic [ADDR_W-1:0]         addr,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx
);

  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |hit_vec;

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R3

endmodule

// File: rtl/vb_age.sv
module vb_age
  import vb_pkg::*;
#(
  parameter int N      = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      valid,
  input  vb_op_e            op,
  input  logic [IDX_W-1:0]  hit_idx,
  output logic [IDX_W-1:0]  repl_idx,
  output logic              full
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  // rank 0 is the newest insertion among valid slots
  logic [N-1:0][IDX_W-1:0] rank_q;
  logic [IDX_W-1:0]        free_idx, oldest_idx;

  assign full = &valid;

  always_comb begin
    free_idx   = '0;
    oldest_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (valid[i] && rank_q[i] == OLDEST) oldest_idx = IDX_W'(i);
    end
  end

  assign repl_idx = full ? oldest_idx : free_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rank_q <= '0;
    end else begin
      case (op)
        VB_FILL_FREE, VB_FILL_DROP: begin
          for (int j = 0; j < N; j++) begin
            if (IDX_W'(j) == repl_idx)  rank_q[j] <= '0;
            else if (valid[j])          rank_q[j] <= rank_q[j] + 1'b1;
          end
        end
        VB_HIT_SWAP: begin
          for (int j = 0; j < N; j++) begin
            if (IDX_W'(j) == hit_idx)                       rank_q[j] <= '0;
            else if (valid[j] && rank_q[j] < rank_q[hit_idx]) rank_q[j] <= rank_q[j] + 1'b1;
          end
        end
        VB_HIT_FREE: begin
          for (int j = 0; j < N; j++) begin
            if (valid[j] && rank_q[j] > rank_q[hit_idx]) rank_q[j] <= rank_q[j] - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_DROP_OLDEST: assert property (@(posedge clk) disable iff (rst)
    (op == VB_FILL_DROP) |-> (full && rank_q[repl_idx] == OLDEST)); // R7

  AST_FILL_EMPTY_SLOT: assert property (@(posedge clk) disable iff (rst)
    (op == VB_FILL_FREE) |-> !valid[repl_idx]); // R6

endmodule

// File: rtl/vb_store.sv
module vb_store
  import vb_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  vb_op_e                    op,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [IDX_W-1:0]          hit_idx,
  input  logic [IDX_W-1:0]          repl_idx,
  input  logic [ADDR_W-1:0]         in_addr,
  input  logic [DATA_W-1:0]         in_data,
  input  logic                      in_dirty,
  output logic [N-1:0][ADDR_W-1:0]  tags,
  output logic [N-1:0]              valid,
  output logic [N-1:0]              dirty,
  output logic [DATA_W-1:0]         hit_data,
  output logic [DATA_W-1:0]         drop_data
);

  logic [DATA_W-1:0] mem [N];
  logic              write_line;

  assign write_line = (op == VB_HIT_SWAP) || (op == VB_FILL_FREE) || (op == VB_FILL_DROP);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      dirty <= '0;
    end else if (write_line) begin
      valid[wr_idx] <= 1'b1;
      dirty[wr_idx] <= in_dirty;
    end else if (op == VB_HIT_FREE) begin
      valid[wr_idx] <= 1'b0;
      dirty[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (write_line) begin
      tags[wr_idx] <= in_addr;
      mem[wr_idx]  <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (op != VB_IDLE) begin
      hit_data  <= mem[hit_idx];
      drop_data <= mem[repl_idx];
    end
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid == '0)); // R1

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vb_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              evict_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][ADDR_W-1:0] tags;
  logic [N-1:0]             valid, dirty;
  logic                     hit, full;
  logic [IDX_W-1:0]         hit_idx, repl_idx, wr_idx;
  vb_op_e                   op;

  vb_match #(.N(N), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .tags(tags), .valid(valid), .addr(req_addr),
    .hit(hit), .hit_idx(hit_idx)
  );

  vb_age #(.N(N)) u_age (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .hit_idx(hit_idx),
    .repl_idx(repl_idx), .full(full)
  );

  always_comb begin
    if (!req_valid)   op = VB_IDLE;
    else if (hit)     op = evict_valid ? VB_HIT_SWAP : VB_HIT_FREE;
    else if (evict_valid) op = full ? VB_FILL_DROP : VB_FILL_FREE;
    else              op = VB_MISS_NOP;
  end

  assign wr_idx = hit ? hit_idx : repl_idx;

  vb_store #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .op(op), .wr_idx(wr_idx), .hit_idx(hit_idx),
    .repl_idx(repl_idx), .in_addr(evict_addr), .in_data(evict_data),
    .in_dirty(evict_dirty), .tags(tags), .valid(valid), .dirty(dirty),
    .hit_data(rsp_data), .drop_data(wb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_dirty <= 1'b0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit;
      rsp_addr  <= req_addr;
      rsp_dirty <= hit && dirty[hit_idx];
      wb_valid  <= (op == VB_FILL_DROP) && dirty[repl_idx];
      wb_addr   <= tags[repl_idx];
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !wb_valid)); // R11

  AST_WB_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (rsp_valid && !rsp_hit)); // R8

  AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !req_valid) |=> !wb_valid); // R8

endmodule

// File: tb/tb_victim_buffer.sv
module tb_victim_buffer;

  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              evict_valid;
  logic [ADDR_W-1:0] evict_addr;
  logic [DATA_W-1:0] evict_data;
  logic              evict_dirty;
  logic              rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [ADDR_W-1:0] rsp_addr, wb_addr;
  logic [DATA_W-1:0] rsp_data, wb_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  victim_buffer #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
    .evict_dirty(evict_dirty), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // line names used by the scenarios
  localparam logic [ADDR_W-1:0] L0 = 'h100, L1 = 'h101, L2 = 'h102, L3 = 'h103,
                                L4 = 'h104, L5 = 'h105, M0 = 'h200, N1 = 'h301,
                                N2 = 'h302, P0 = 'h400, P1 = 'h401, P2 = 'h402;
  localparam logic [ADDR_W-1:0] NONE = 'h3FF0;

  function automatic logic [DATA_W-1:0] dat(input logic [ADDR_W-1:0] a);
    return {6'h2B, a} ^ 32'h0F0F_0000;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // drives one request at a negedge, samples at the following negedge
  task automatic access(input string rq, input logic [ADDR_W-1:0] a,
                        input logic ev, input logic [ADDR_W-1:0] ea, input logic ed,
                        input logic exp_hit, input logic exp_dirty,
                        input logic exp_wb, input logic [ADDR_W-1:0] exp_wb_addr);
    req_valid   = 1'b1;
    req_addr    = a;
    evict_valid = ev;
    evict_addr  = ea;
    evict_data  = dat(ea);
    evict_dirty = ed;
    @(negedge clk);
    req_valid   = 1'b0;
    evict_valid = 1'b0;
    chk({rq, " rsp_valid (R2)"}, 64'(rsp_valid), 64'(1'b1));
    chk({rq, " rsp_hit"}, 64'(rsp_hit), 64'(exp_hit));
    if (exp_hit) begin
      chk({rq, " rsp_addr (R3)"}, 64'(rsp_addr), 64'(a));
      chk({rq, " rsp_data (R3)"}, 64'(rsp_data), 64'(dat(a)));
      chk({rq, " rsp_dirty (R3)"}, 64'(rsp_dirty), 64'(exp_dirty));
    end
    chk({rq, " wb_valid"}, 64'(wb_valid), 64'(exp_wb));
    if (exp_wb) begin
      chk({rq, " wb_addr (R8)"}, 64'(wb_addr), 64'(exp_wb_addr));
      chk({rq, " wb_data (R8)"}, 64'(wb_data), 64'(dat(exp_wb_addr)));
    end
  endtask

  task automatic probe(input string rq, input logic [ADDR_W-1:0] a,
                       input logic exp_hit, input logic exp_dirty);
    access(rq, a, 1'b0, '0, 1'b0, exp_hit, exp_dirty, 1'b0, '0);
  endtask

  task automatic fill(input string rq, input logic [ADDR_W-1:0] ea, input logic ed,
                      input logic exp_wb, input logic [ADDR_W-1:0] exp_wb_addr);
    access(rq, NONE, 1'b1, ea, ed, 1'b0, 1'b0, exp_wb, exp_wb_addr);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    req_valid = 1'b0; req_addr = '0; evict_valid = 1'b0;
    evict_addr = '0; evict_data = '0; evict_dirty = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'(1'b0));
    chk("R1 wb_valid in reset", 64'(wb_valid), 64'(1'b0));
    rst = 1'b0;
    probe("R1 first lookup", L0, 1'b0, 1'b0);
  endtask

  task automatic t_fill_free();
    fill("R6 fill L0", L0, 1'b1, 1'b0, '0);
    fill("R6 fill L1", L1, 1'b0, 1'b0, '0);
    fill("R6 fill L2", L2, 1'b0, 1'b0, '0);
    fill("R6 fill L3", L3, 1'b1, 1'b0, '0);
  endtask

  task automatic t_replace();
    fill("R7 R8 dirty drop L0", L4, 1'b1, 1'b1, L0);
    fill("R7 R8 clean drop L1", L5, 1'b0, 1'b0, '0);
    probe("R7 L0 gone", L0, 1'b0, 1'b0);
    probe("R7 L1 gone", L1, 1'b0, 1'b0);
  endtask

  task automatic t_swap();
    access("R3 R4 swap L3<-M0", L3, 1'b1, M0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
    probe("R4 L3 left", L3, 1'b0, 1'b0);
    fill("R10 drop L2", N1, 1'b1, 1'b0, '0);
    probe("R10 L2 gone", L2, 1'b0, 1'b0);
    fill("R10 drop L4 not M0", N2, 1'b0, 1'b1, L4);
  endtask

  task automatic t_free_hole();
    probe("R4 R5 M0 hit frees", M0, 1'b1, 1'b1);
    probe("R5 M0 freed", M0, 1'b0, 1'b0);
    fill("R6 fill hole P0", P0, 1'b0, 1'b0, '0);
    fill("R7 drop L5 clean", P1, 1'b0, 1'b0, '0);
    probe("R7 L5 gone", L5, 1'b0, 1'b0);
    fill("R7 R8 drop N1 dirty", P2, 1'b0, 1'b1, N1);
  endtask

  task automatic t_nop_and_idle();
    probe("R9 miss no evict", 'h3AB, 1'b0, 1'b0);
    probe("R9 N2 kept", N2, 1'b1, 1'b0);
    probe("R9 P0 kept", P0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R11 idle rsp_valid", 64'(rsp_valid), 64'(1'b0));
    chk("R11 idle wb_valid", 64'(wb_valid), 64'(1'b0));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_fill_free();
    t_replace();
    t_swap();
    t_free_hole();
    t_nop_and_idle();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
    finish_run();
  end

endmodule